// File: doc/BRIEF.md
# Register-Mapped GPIO Bank

A bank-tiled general-purpose I/O port of 32 pins per bank, reached over a simple 32-bit read/write bus. Each pin has an output latch, a direction bit and a glitch-filter bypass bit. Each pin also returns an input level that passes through a two-flop synchronizer and, optionally, a stability filter. Software changes the output latch only through two write-only ports. One port sets every latch bit written as 1. The other clears every latch bit written as 1. A pin can therefore be preloaded with its value before it is turned into an output.

Several banks can be tiled under the parameter `NBANK`. Inside each register group, bank n sits at the group offset plus 4*n. Pin p of the whole port belongs to bank p/32 and to bit p%32 of that bank's word. The group offsets are fixed:

| Group | Offset |
|---|---|
| level | 0x004 |
| direction | 0x01C |
| set | 0x034 |
| clear | 0x04C |
| bypass | 0x094 |

Word 0x000 is reserved and reads as zero. The spacing between the level and direction groups limits `NBANK` to 6.

Top module: `gpb_port_bank`

## Requirements
- R1: While reset is high and after it is released, every direction bit, latch bit and bypass bit is 0. This means `pad_oe`, `pad_out` and `bus_rdata` are all zero.
- R2: The direction word of bank n (offset 0x01C+4n) can be read and written. Bit b set to 1 makes pin 32n+b an output, and `pad_oe` follows from the clock edge that takes the write.
- R3: A write to the set port (0x034+4n) makes the latch bits that have data 1 equal to 1 and leaves all other bits unchanged. A read of the set port returns zero.
- R4: A write to the clear port (0x04C+4n) makes the latch bits that have data 1 equal to 0 and leaves all other bits unchanged. A read of the clear port returns zero.
- R5: The latch is independent of direction. A value preloaded while the pin is an input appears on `pad_out` unchanged when the pin becomes an output, and writes to the direction word never alter the latch.
- R6: A read of the level word (0x004+4n) returns `pin_level` for that bank. Writes to the level word change nothing.
- R7: With its bypass bit at 1, a pin's `pin_level` equals the `pad_in` value sampled two clock edges earlier.
- R8: With its bypass bit at 0, a pin's `pin_level` takes a new value only after the synchronized input has shown that value on 3 consecutive edges. This is 5 edges after the pad changes. Pulses shorter than 3 samples are dropped.
- R9: The bypass word (0x094+4n) can be read and written. A 1 selects the raw synchronized input and a 0 selects the filtered input.
- R10: Reads of 0x000, of unaligned or unused words, and of banks at index `NBANK` or above return zero. Writes to those addresses change no state.
- R11: `bus_rdata` is registered. It carries the read value after the edge that samples `bus_rd`, and it is zero after any edge without a read.
- R12: Bank n controls and reports exactly pins 32n to 32n+31 of the pin vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32*NBANK | Raw pin inputs |
| pad_oe | output | 32*NBANK | Output enables, equal to the direction bits |
| pad_out | output | 32*NBANK | Output latch values |
| pin_level | output | 32*NBANK | Synchronized, optionally filtered input levels |

## Verification
Register writes take effect on `pad_oe` and `pad_out` one edge after the write strobe. Read data is due one edge after the read strobe. A bypassed level is due two edges after a pad change, and a filtered level is due five edges after it. The bench drives every input on the falling edge. It then counts falling edges from the stimulus and compares each result on the first falling edge where it is due, and also on the one before, to show it is not early. For the sweeps over the address space and register patterns, the pads are held steady long enough that every level has settled before any read.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int WORD_W   = 32;
    localparam int OFF_LVL  = 'h004;
    localparam int OFF_DIR  = 'h01C;
    localparam int OFF_SET  = 'h034;
    localparam int OFF_CLR  = 'h04C;
    localparam int OFF_BYP  = 'h094;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_CFG,
        GRP_LVL,
        GRP_DIR,
        GRP_SET,
        GRP_CLR,
        GRP_BYP
    } grp_e;

    typedef struct packed {
        grp_e       grp;
        logic [3:0] bank;
    } dec_t;

    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic byp;
    } bank_we_t;

    function automatic logic in_group(input logic [31:0] addr, input int off, input int nbank);
        return (addr >= 32'(off)) && (addr < 32'(off + 4 * nbank));
    endfunction

    function automatic logic [3:0] bank_of(input logic [31:0] addr, input int off);
        logic [31:0] rel;
        rel = (addr - 32'(off)) >> 2;
        return rel[3:0];
    endfunction

    function automatic dec_t decode(input logic [31:0] addr, input int nbank);
        dec_t d;
        d.grp  = GRP_NONE;
        d.bank = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == 32'h0) begin
                d.grp = GRP_CFG;
            end else if (in_group(addr, OFF_LVL, nbank)) begin
                d.grp = GRP_LVL; d.bank = bank_of(addr, OFF_LVL);
            end else if (in_group(addr, OFF_DIR, nbank)) begin
                d.grp = GRP_DIR; d.bank = bank_of(addr, OFF_DIR);
            end else if (in_group(addr, OFF_SET, nbank)) begin
                d.grp = GRP_SET; d.bank = bank_of(addr, OFF_SET);
            end else if (in_group(addr, OFF_CLR, nbank)) begin
                d.grp = GRP_CLR; d.bank = bank_of(addr, OFF_CLR);
            end else if (in_group(addr, OFF_BYP, nbank)) begin
                d.grp = GRP_BYP; d.bank = bank_of(addr, OFF_BYP);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpb_filter.sv
module gpb_filter #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int CW = (STABLE > 2) ? $clog2(STABLE) : 1;

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            run <= '0;
        end else if (d == q) begin
            run <= '0;
        end else if (run == CW'(STABLE - 1)) begin
            q   <= d;
            run <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int W      = 32,
    parameter int STABLE = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  bank_we_t     we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] oe,
    output logic [W-1:0] out,
    output logic [W-1:0] byp,
    output logic [W-1:0] level
);
    logic [W-1:0] synced;
    logic [W-1:0] filtered;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe  <= '0;
            out <= '0;
            byp <= '0;
        end else begin
            if (we.dir) oe  <= wdata;
            if (we.byp) byp <= wdata;
            if (we.set) out <= out | wdata;
            else if (we.clr) out <= out & ~wdata;
        end
    end

    gpb_sync #(.W(W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (synced)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpb_filter #(.STABLE(STABLE)) u_flt (
            .clk (clk),
            .rst (rst),
            .d   (synced[i]),
            .q   (filtered[i])
        );
        assign level[i] = byp[i] ? synced[i] : filtered[i];
    end
endmodule

// File: rtl/gpb_port_bank.sv
module gpb_port_bank
    import gpb_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int AW     = 12,
    parameter int STABLE = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [32*NBANK-1:0]   pad_in,
    output logic [32*NBANK-1:0]   pad_oe,
    output logic [32*NBANK-1:0]   pad_out,
    output logic [32*NBANK-1:0]   pin_level
);
    localparam int NPIN = WORD_W * NBANK;

    dec_t               dec;
    logic [WORD_W-1:0]  rd_val;
    logic [WORD_W-1:0]  dir_w [NBANK];
    logic [WORD_W-1:0]  byp_w [NBANK];
    logic [WORD_W-1:0]  lvl_w [NBANK];
    logic [NPIN-1:0]    byp_all;

    assign dec = decode({{(32-AW){1'b0}}, bus_addr}, NBANK);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_we_t we;
        logic     hit;

        assign hit    = bus_wr && (dec.bank == 4'(b));
        assign we.dir = hit && (dec.grp == GRP_DIR);
        assign we.set = hit && (dec.grp == GRP_SET);
        assign we.clr = hit && (dec.grp == GRP_CLR);
        assign we.byp = hit && (dec.grp == GRP_BYP);

        gpb_bank #(.W(WORD_W), .STABLE(STABLE)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .we     (we),
            .wdata  (bus_wdata),
            .pad_in (pad_in[WORD_W*b +: WORD_W]),
            .oe     (dir_w[b]),
            .out    (pad_out[WORD_W*b +: WORD_W]),
            .byp    (byp_w[b]),
            .level  (lvl_w[b])
        );

        assign pad_oe[WORD_W*b +: WORD_W]    = dir_w[b];
        assign pin_level[WORD_W*b +: WORD_W] = lvl_w[b];
        assign byp_all[WORD_W*b +: WORD_W]   = byp_w[b];
    end

    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (dec.bank == 4'(b)) begin
                case (dec.grp)
                    GRP_LVL: rd_val = lvl_w[b];
                    GRP_DIR: rd_val = dir_w[b];
                    GRP_BYP: rd_val = byp_w[b];
                    default: rd_val = rd_val;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
        else             bus_rdata <= '0;
    end
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
    parameter int NBANK = 2,
    parameter int AW    = 12
) (
    input logic                clk,
    input logic                rst,
    input logic [AW-1:0]       bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [32*NBANK-1:0] pad_in,
    input logic [32*NBANK-1:0] pad_oe,
    input logic [32*NBANK-1:0] pad_out,
    input logic [32*NBANK-1:0] pin_level,
    input logic [32*NBANK-1:0] byp_all
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 3'd7) age <= age + 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pad_oe == '0) && (pad_out == '0) && (bus_rdata == '0));

    p_set_bank0_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'('h034)) |=>
            ((pad_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_bank0_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == AW'('h04C)) |=>
            ((pad_out[31:0] & $past(bus_wdata)) == 32'h0));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(pad_out) && $stable(pad_oe)));

    p_bypass_lag_r7: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd3 && byp_all[0]) |-> (pin_level[0] == $past(pad_in[0], 2)));

    p_filter_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd6 && !byp_all[0] && !$past(byp_all[0]) &&
         pin_level[0] != $past(pin_level[0])) |->
            ($past(pad_in[0], 3) == pin_level[0] &&
             $past(pad_in[0], 4) == pin_level[0] &&
             $past(pad_in[0], 5) == pin_level[0]));

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == '0) |=> (bus_rdata == 32'h0));

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == 32'h0));

endmodule

bind gpb_port_bank gpb_checker #(.NBANK(NBANK), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pin_level (pin_level),
    .byp_all   (byp_all)
);

// File: tb/sim_gpb_port_bank.sv
module sim_gpb_port_bank;
    localparam int NB = 2;
    localparam int AW = 12;
    localparam int NP = 32 * NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pin_level;

    int n_chk = 0;
    int n_bad = 0;
    logic          done = 1'b0;
    logic [31:0]   m_dir [NB];
    logic [31:0]   m_out [NB];
    logic [31:0]   m_byp [NB];

    always #10 clk = ~clk;

    gpb_port_bank #(.NBANK(NB), .AW(AW)) u0 (
        .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
        .pad_in, .pad_oe, .pad_out, .pin_level
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_read(input int a);
        for (int b = 0; b < NB; b++) begin
            if (a == 'h004 + 4*b) return pin_level[32*b +: 32] === 'x ? 'x : pad_in[32*b +: 32];
            if (a == 'h01C + 4*b) return m_dir[b];
            if (a == 'h094 + 4*b) return m_byp[b];
        end
        return 32'h0;
    endfunction

    function automatic logic writable(input int a);
        for (int b = 0; b < NB; b++)
            if (a == 'h01C + 4*b || a == 'h034 + 4*b || a == 'h04C + 4*b || a == 'h094 + 4*b)
                return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [NP-1:0] cat(input logic [31:0] w0, input logic [31:0] w1);
        return {w1, w0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0001; pats[2] = 32'h8000_0000;
        pats[3] = 32'hA5A5_5A5A; pats[4] = 32'h0F0F_00F0; pats[5] = 32'h1234_5678;
        for (int b = 0; b < NB; b++) begin m_dir[b] = '0; m_out[b] = '0; m_byp[b] = '0; end

        repeat (3) @(negedge clk);
        check("R1 oe in reset", 64'(pad_oe), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 oe", 64'(pad_oe), 64'h0);
        check("R1 out", 64'(pad_out), 64'h0);
        check("R1 rdata", 64'(bus_rdata), 64'h0);

        // R6 R10 R11 R12: full word-address sweep with settled pads
        pad_in = 64'hA5A5_0F0F_3C3C_F00D;
        repeat (10) @(negedge clk);
        for (int a = 0; a < (1 << AW); a += 4) begin
            rd(a, r);
            check($sformatf("R10 R6 sweep @%0h", a), 64'(r), 64'(exp_read(a)));
        end
        rd('h006, r);
        check("R10 unaligned", 64'(r), 64'h0);
        @(negedge clk);
        check("R11 idle rdata", 64'(bus_rdata), 64'h0);

        // R3 R4 R12: set/clear sequences per bank
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 6; k++) begin
                wr('h034 + 4*b, pats[k]);
                m_out[b] |= pats[k];
                check($sformatf("R3 set b%0d k%0d", b, k), 64'(pad_out), 64'(cat(m_out[0], m_out[1])));
                wr('h04C + 4*b, pats[(k + 3) % 6]);
                m_out[b] &= ~pats[(k + 3) % 6];
                check($sformatf("R4 clr b%0d k%0d", b, k), 64'(pad_out), 64'(cat(m_out[0], m_out[1])));
            end
            rd('h034 + 4*b, r);
            check("R3 set reads zero", 64'(r), 64'h0);
            rd('h04C + 4*b, r);
            check("R4 clr reads zero", 64'(r), 64'h0);
        end

        // R2 R12: direction patterns
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < 6; k++) begin
                wr('h01C + 4*b, pats[k] ^ 32'(b));
                m_dir[b] = pats[k] ^ 32'(b);
                check($sformatf("R2 oe b%0d k%0d", b, k), 64'(pad_oe), 64'(cat(m_dir[0], m_dir[1])));
                check("R5 latch kept on dir write", 64'(pad_out), 64'(cat(m_out[0], m_out[1])));
                rd('h01C + 4*b, r);
                check("R2 dir readback", 64'(r), 64'(m_dir[b]));
            end
        end

        // R5: preload then turn on the driver
        wr('h01C, 32'h0);       m_dir[0] = '0;
        wr('h04C, 32'hFFFF_FFFF); m_out[0] = '0;
        wr('h034, 32'h0000_0080); m_out[0] = 32'h80;
        check("R5 preload no drive", 64'(pad_oe[31:0]), 64'h0);
        wr('h01C, 32'h0000_0080); m_dir[0] = 32'h80;
        check("R5 out after enable", 64'(pad_out[31:0]), 64'h80);
        check("R5 oe after enable", 64'(pad_oe[31:0]), 64'h80);

        // R6: level word ignores writes
        wr('h004, 32'hFFFF_FFFF);
        wr('h008, 32'h0000_0000);
        rd('h004, r);
        check("R6 level after write b0", 64'(r), 64'(pad_in[31:0]));
        rd('h008, r);
        check("R6 level after write b1", 64'(r), 64'(pad_in[63:32]));

        // R10: writes to every non-writable word change nothing
        for (int a = 0; a < (1 << AW); a += 4)
            if (!writable(a)) wr(a, 32'hFFFF_FFFF);
        check("R10 out untouched", 64'(pad_out), 64'(cat(m_out[0], m_out[1])));
        check("R10 oe untouched", 64'(pad_oe), 64'(cat(m_dir[0], m_dir[1])));
        rd('h094, r);
        check("R10 byp untouched", 64'(r), 64'h0);

        // R9: bypass pin 5 of bank 0, and a bank-1 pattern
        wr('h094, 32'h0000_0020); m_byp[0] = 32'h20;
        wr('h098, 32'hC000_0003); m_byp[1] = 32'hC000_0003;
        rd('h094, r);
        check("R9 byp readback b0", 64'(r), 64'h20);
        rd('h098, r);
        check("R9 byp readback b1", 64'(r), 64'hC000_0003);

        // R7 R8: rising edge on pins 5 (bypass) and 6 (filtered)
        @(negedge clk);
        pad_in[6:5] = 2'b11;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            check($sformatf("R7 rise n%0d", n), 64'(pin_level[5]), 64'(n >= 2));
            check($sformatf("R8 rise n%0d", n), 64'(pin_level[6]), 64'(n >= 5));
        end
        pad_in[6:5] = 2'b00;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            check($sformatf("R7 fall n%0d", n), 64'(pin_level[5]), 64'(n < 2));
            check($sformatf("R8 fall n%0d", n), 64'(pin_level[6]), 64'(n < 5));
        end

        // R8: two-sample pulse rejected on filtered pin, visible on bypassed pin
        pad_in[6:5] = 2'b11;
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (n == 2) pad_in[6:5] = 2'b00;
            check($sformatf("R8 short pulse n%0d", n), 64'(pin_level[6]), 64'h0);
            check($sformatf("R7 short pulse n%0d", n), 64'(pin_level[5]), 64'(n == 2 || n == 3));
        end

        // R8: three-sample pulse accepted
        pad_in[6] = 1'b1;
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (n == 3) pad_in[6] = 1'b0;
            check($sformatf("R8 long pulse n%0d", n), 64'(pin_level[6]), 64'(n >= 5 && n <= 7));
        end

        // R8: filtered bank-1 pin 40 settles to the pad, bypassed pin 33 too
        pad_in[40] = ~pad_in[40];
        pad_in[33] = ~pad_in[33];
        repeat (8) @(negedge clk);
        check("R8 R12 bank1 filtered settle", 64'(pin_level), 64'(pad_in));
        check("R12 bank1 level read", 64'(pin_level[63:32]), 64'(pad_in[63:32]));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule